// File: doc/BRIEF.md
# Pulse Event Counter with Compare Interrupt

This block counts pulses arriving on an asynchronous input pin, sampled by the system clock. A two-stage synchronizer brings the pin into the clock domain, and edge detection follows it. Each rising edge of the synchronized pin advances an 8-bit count. The count is compared with a programmable compare value only when the following falling edge is seen. When the two are equal, the block emits a one-clock interrupt pulse and the count returns to zero. The next rising edge then brings the count to one.

Software programs the compare value while the block is stopped and then sets the run control. When capture is enabled, a capture register follows the live count so that software can read it. The zero that the count holds just after a compare hit is never copied, so the capture register keeps showing the terminal count until the next pulse arrives.

The capture register is a plain level output and has no handshake: it is a status value, not a stream. The compare value write port is likewise a plain write strobe.

Top module: `evc_top`

## Requirements
- R1: After reset, irq_o is 0, cap_value_o is 0x00, the count is 0 and the compare value is 0x00.
- R2: While run_i is 1, each rising edge of the synchronized pin raises the count by one, wrapping from 0xFF to 0x00.
- R3: The compare is evaluated only on a synchronized falling edge. A pin low level first sampled at clock edge k produces irq_o high after edge k+2, provided the count equals the compare value and at least one rising edge has occurred since the last clear or start.
- R4: On a compare hit the count becomes 0 at the same clock edge that raises irq_o. The count sequence around a hit is n, 0, 1.
- R5: While cap_en_i is 1, cap_value_o takes the count one clock later. While cap_en_i is 0, cap_value_o holds its value.
- R6: The zero loaded by a compare hit is not captured. cap_value_o keeps the previous count until the next rising edge moves the count.
- R7: While run_i is 0, the count is held at 0 and irq_o stays 0. After run_i returns to 1, counting restarts from 0.
- R8: A compare value of 0x00 gives one interrupt every 256 pulses.
- R9: A write on cmp_we_i with cmp_wdata_i is accepted only while run_i is 0. A write made while running has no effect.
- R10: irq_o is high for exactly one clock per hit.
- R11: With a compare value of 0x19, an interrupt occurs on every 25th pulse (a 50 Hz input then gives one interrupt every 0.5 s). Pulses must be at least 4 clocks high and 4 clocks low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pin_i | input | 1 | Asynchronous event pulse input |
| run_i | input | 1 | 1 counts; 0 stops and clears |
| cap_en_i | input | 1 | Auto-capture enable |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | 8 | Compare value write data |
| cap_value_o | output | 8 | Captured count |
| irq_o | output | 1 | One-clock interrupt pulse |

## Verification
The block is driven with pulse trains whose high and low widths vary between 4 and 7 clocks. The varying widths show that counting depends on edges, not on levels, and that the interrupt follows the falling edge with a fixed latency. Runs with small compare values separate a correct clear-to-zero from an off-by-one terminal count. A run with compare value 0x19 and a run with 0x00 exercise the 25-pulse interval and the 256-pulse wrap. Stretches with capture disabled, a write made while running, and a stop/restart in the middle of a count show that each of those has its own effect on the outputs and no other effect.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/evc_edge_sync.sv
module evc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic rise_i,
  input  logic fall_i,
  input  cnt_t cmp_i,
  output cnt_t cnt_o,
  output logic hold_o,
  output logic irq_o
);
  cnt_t cnt_q;
  logic armed_q;
  logic hold_q;
  logic irq_q;
  logic hit;

  assign hit = fall_i & armed_q & (cnt_q == cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      hold_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      hold_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= hit;
      if (hit) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        hold_q  <= 1'b1;
      end else if (rise_i) begin
        cnt_q   <= cnt_q + 1'b1;
        armed_q <= 1'b1;
        hold_q  <= 1'b0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/evc_capture.sv
module evc_capture
  import evc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hold_i,
  input  cnt_t cnt_i,
  output cnt_t cap_o
);
  cnt_t cap_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               cap_q <= '0;
    else if (en_i && !hold_i) cap_q <= cnt_i;

  assign cap_o = cap_q;
endmodule

// File: rtl/evc_top.sv
module evc_top
  import evc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_pin_i,
  input  logic             run_i,
  input  logic             cap_en_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] cap_value_o,
  output logic             irq_o
);
  logic ev_rise;
  logic ev_fall;
  logic cnt_hold;
  cnt_t cnt_q;
  cnt_t cmp_q;

  // Compare value: writable only while stopped
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cmp_q <= '0;
    else if (cmp_we_i && !run_i) cmp_q <= cmp_wdata_i;

  evc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (evt_pin_i),
    .rise_o (ev_rise),
    .fall_o (ev_fall)
  );

  evc_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_i),
    .rise_i (ev_rise),
    .fall_i (ev_fall),
    .cmp_i  (cmp_q),
    .cnt_o  (cnt_q),
    .hold_o (cnt_hold),
    .irq_o  (irq_o)
  );

  evc_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (cap_en_i),
    .hold_i (cnt_hold),
    .cnt_i  (cnt_q),
    .cap_o  (cap_value_o)
  );
endmodule

// File: rtl/evc_chk.sv
module evc_chk
  import evc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic cap_en,
  input logic rise,
  input logic fall,
  input logic irq,
  input cnt_t cnt,
  input cnt_t cmp,
  input cnt_t cap
);
  p_one_clock_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_hit_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == '0));
  p_irq_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(fall) && $past(run)));
  p_stopped_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !irq));
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rise) |=> (cnt == cnt_t'($past(cnt) + 1'b1)));
  p_cmp_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cmp == $past(cmp)));
  p_cap_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap));
endmodule

bind evc_top evc_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (run_i),
  .cap_en (cap_en_i),
  .rise   (ev_rise),
  .fall   (ev_fall),
  .irq    (irq_o),
  .cnt    (cnt_q),
  .cmp    (cmp_q),
  .cap    (cap_value_o)
);

// File: tb/test_evc_top.sv
`timescale 1ns/1ps
module test_evc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_pin = 1'b0;
  logic       run = 1'b0;
  logic       cap_en = 1'b0;
  logic       cmp_we = 1'b0;
  logic [7:0] cmp_wdata = 8'h00;
  logic [7:0] cap_value;
  logic       irq;

  always #4 clk = ~clk;

  evc_top i_evc_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pin_i   (evt_pin),
    .run_i       (run),
    .cap_en_i    (cap_en),
    .cmp_we_i    (cmp_we),
    .cmp_wdata_i (cmp_wdata),
    .cap_value_o (cap_value),
    .irq_o       (irq)
  );

  int vectors = 0;
  int errors  = 0;
  int irq_seen = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int   hist[$];
  int   m_cnt, m_cmp, m_cap;
  bit   m_armed, m_hold, m_irq, m_rise, m_fall, m_hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_cnt = 0; m_cmp = 0; m_cap = 0;
      m_armed = 0; m_hold = 0; m_irq = 0;
    end else begin
      m_rise = (hist[1] == 1) && (hist[2] == 0);
      m_fall = (hist[1] == 0) && (hist[2] == 1);
      if (cap_en && !m_hold) m_cap = m_cnt;
      if (!run) begin
        m_cnt = 0; m_armed = 0; m_hold = 0; m_irq = 0;
      end else begin
        m_hit = m_fall && m_armed && (m_cnt == m_cmp);
        m_irq = m_hit;
        if (m_hit) begin
          m_cnt = 0; m_armed = 0; m_hold = 1;
        end else if (m_rise) begin
          m_cnt = (m_cnt + 1) % 256; m_armed = 1; m_hold = 0;
        end
      end
      if (cmp_we && !run) m_cmp = cmp_wdata;
      hist.push_front(int'(evt_pin));
      void'(hist.pop_back());
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(irq == m_irq, "R3/R4/R10 irq", irq, m_irq);
      check(cap_value == m_cap[7:0], "R2/R5/R6 capture", cap_value, m_cap);
      if (irq) irq_seen++;
    end
  end

  task automatic pulse(input int hi, input int lo);
    evt_pin = 1'b1;
    repeat (hi) @(negedge clk);
    evt_pin = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic write_cmp(input int v);
    cmp_wdata = v[7:0];
    cmp_we = 1'b1;
    @(negedge clk);
    cmp_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int base;
    int last_cap;
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check(cap_value == 8'h00, "R1 capture after reset", cap_value, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: compare 5 programmed while stopped
    write_cmp(5);
    cap_en = 1'b1;
    run = 1'b1;
    @(negedge clk);

    // R2/R3/R4: 12 pulses of varying width -> 2 hits
    base = irq_seen;
    for (int i = 0; i < 12; i++) pulse(4 + (i % 4), 4 + ((i + 2) % 4));
    check(irq_seen - base == 2, "R3 hits over 12 pulses", irq_seen - base, 2);
    check(cap_value == 8'd2, "R2 live count after 12 pulses", cap_value, 2);

    // R9: write while running ignored -> still 5 pulses per hit
    write_cmp(1);
    base = irq_seen;
    for (int i = 0; i < 3; i++) pulse(5, 4);
    check(irq_seen - base == 1, "R9 ignored write, hit after 5", irq_seen - base, 1);
    // R6: zero after hit is not captured
    check(cap_value == 8'd5, "R6 capture keeps terminal count", cap_value, 5);
    pulse(4, 4);
    check(cap_value == 8'd1, "R4 count resumes at 1", cap_value, 1);

    // R5: capture disabled holds
    cap_en = 1'b0;
    pulse(4, 6);
    pulse(6, 4);
    check(cap_value == 8'd1, "R5 capture held while disabled", cap_value, 1);
    cap_en = 1'b1;
    repeat (2) @(negedge clk);
    check(cap_value == 8'd3, "R5 capture resumes", cap_value, 3);

    // R7: stop clears and suppresses
    run = 1'b0;
    base = irq_seen;
    for (int i = 0; i < 8; i++) pulse(4, 4);
    check(irq_seen == base, "R7 no irq while stopped", irq_seen - base, 0);
    check(cap_value == 8'd0, "R7 count zero while stopped", cap_value, 0);

    // R11: compare 0x19 -> every 25th pulse
    write_cmp(8'h19);
    run = 1'b1;
    @(negedge clk);
    base = irq_seen;
    for (int i = 0; i < 24; i++) pulse(4, 5);
    check(irq_seen == base, "R11 no irq before 25th pulse", irq_seen - base, 0);
    pulse(4, 5);
    check(irq_seen - base == 1, "R11 irq at 25th pulse", irq_seen - base, 1);
    for (int i = 0; i < 25; i++) pulse(5, 4);
    check(irq_seen - base == 2, "R11 irq at 50th pulse", irq_seen - base, 2);

    // R8: compare 0 -> 256 pulses
    run = 1'b0;
    @(negedge clk);
    write_cmp(0);
    run = 1'b1;
    @(negedge clk);
    base = irq_seen;
    for (int i = 0; i < 255; i++) pulse(4, 4);
    check(irq_seen == base, "R8 no irq before 256th pulse", irq_seen - base, 0);
    check(cap_value == 8'hFF, "R2 count at 255", cap_value, 255);
    pulse(4, 4);
    check(irq_seen - base == 1, "R8 irq at 256th pulse", irq_seen - base, 1);
    last_cap = cap_value;
    check(last_cap == 0, "R8 wrapped count captured", last_cap, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule